// File: doc/BRIEF.md
# Overlapped byte-serial block pipeline controller

This block controls the data path around a 64-bit block transform that has a byte-wide write port and a separate byte-wide read port. A producer writes a block as eight bytes, one per clock, into an input staging register. The block then moves into a processing unit that has a fixed latency. The result moves into an output staging register, and a consumer reads it out as eight bytes. Loading, processing and unloading run as independent stages. A new block can therefore be loaded while an earlier one is still being processed, and a finished result can be read while the next one is being computed.

Each port has a ready flag: `in_ready` on the write side and `out_ready` on the read side. When the pipeline is kept full, one block leaves every 18 clocks. A single block on its own takes 39 clocks from its first byte written to its last byte read. The processing unit is a stand-in. It XORs the block with a 64-bit constant and rotates the result left by 8 bits, so a bench can check the data as well as the timing. If the output register still holds unread data when a result is ready, the processing unit waits, so no block is ever overwritten.

Top module: `blkpipe_ctrl`

## Requirements
- R1: A synchronous active-low reset leaves `in_ready` = 1, `out_ready` = 0 and `rd_data` = 0, and clears both byte counters. A block written after a reset that interrupted a partial write is assembled from its own eight bytes only.
- R2: While `in_ready` is 1, each clock with `wr_en` = 1 accepts one byte. The first byte accepted becomes bits 63:56 of the block, and each later byte fills the next lower byte. `in_ready` falls right after the edge that accepts the eighth byte.
- R3: If the processing unit is free when the eighth byte is accepted, processing starts on that same edge, and `in_ready` returns to 1 five clocks after that edge.
- R4: For a block that finds the pipeline idle, `out_ready` rises 23 clocks after the edge that accepts its eighth byte. This is 18 clocks of processing followed by 5 clocks of transfer.
- R5: The result is ((block XOR 64'hA5C3_0F96_5A3C_F069) rotated left by 8). It is read out most significant byte first. Each clock with `rd_en` = 1 and `out_ready` = 1 puts the next byte on `rd_data` after that edge. `out_ready` falls after the eighth read.
- R6: A `wr_en` strobe while `in_ready` is 0 is ignored. It changes neither the block in flight nor the byte position of the next block.
- R7: A `rd_en` strobe while `out_ready` is 0 leaves `rd_data` unchanged and does not advance the read position.
- R8: A block that completes while the processing unit is busy waits in the input register. Processing of that block starts on the edge where the previous result leaves the unit. `in_ready` returns 5 clocks after that start. With continuous traffic, consecutive `out_ready` rises are exactly 18 clocks apart.
- R9: If a result is ready while the output register still holds unread bytes, the processing unit holds the result. It hands the result over on the clock after the eighth read, and `out_ready` rises 6 clocks after that eighth read. The input block waiting behind it starts on that same hand-over edge, and no data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to write |
| in_ready | output | 1 | Input register accepts bytes |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | 8 | Last byte read, registered |
| out_ready | output | 1 | Output register holds a readable block |

## Verification
Every timing result is measured in edges from one anchor: the edge that accepts a block's eighth byte. `in_ready` is due 5 edges after processing starts, and `out_ready` 23 edges after the anchor when the pipeline is idle. Each read byte appears on `rd_data` one edge after its strobe. In a stalled pipeline, the next result's `out_ready` is due 6 edges after the last read. The bench keeps a free-running edge counter and drives inputs and samples outputs on the falling clock edge. Two watchers record the exact edge on which each flag first rises, and every timing check compares that edge number with the anchor plus the stated offset. Data checks compare each assembled read-out against the transform computed in the bench.

// File: rtl/blkpipe_pkg.sv
// Package: shared stage encodings for the block pipeline controller.
// Assumes: nothing; holds type definitions only.
package blkpipe_pkg;

    // Input side: collecting bytes, holding a full block, or in hand-over delay.
    typedef enum logic [1:0] {
        IN_LOAD = 2'd0,
        IN_FULL = 2'd1,
        IN_XFER = 2'd2
    } in_state_e;

    // Output side: no block, hand-over delay, or block available to read.
    typedef enum logic [1:0] {
        OUT_EMPTY = 2'd0,
        OUT_XFER  = 2'd1,
        OUT_FULL  = 2'd2
    } out_state_e;

endpackage

// File: rtl/blkpipe_in.sv
// Module: input staging. Assembles a block from byte writes, MSB first, and
// offers it to the processing unit. Once the unit takes the block, the flag
// stays low for XFER_CYC clocks before the next block can be written.
// Assumes: BLK_W is a multiple of BYTE_W, XFER_CYC >= 1, and alg_free is a
// same-cycle signal from the processing unit.
module blkpipe_in
    import blkpipe_pkg::*;
#(
    parameter int BLK_W    = 64,
    parameter int BYTE_W   = 8,
    parameter int XFER_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              alg_free,
    output logic              in_ready,
    output logic              blk_start,
    output logic [BLK_W-1:0]  blk_data
);
    localparam int NBYTES = BLK_W / BYTE_W;
    localparam int CW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int XW     = $clog2(XFER_CYC + 1);

    in_state_e         st_q;
    logic [CW-1:0]     cnt_q;
    logic [XW-1:0]     xcnt_q;
    logic [BLK_W-1:0]  sh_q;
    logic              wr_fire;
    logic              last_byte;
    logic              blk_ready;

    // Accept, completion and hand-over decode.
    always_comb begin
        wr_fire   = wr_en && (st_q == IN_LOAD);
        last_byte = wr_fire && (cnt_q == CW'(NBYTES - 1));
        blk_ready = last_byte || (st_q == IN_FULL);
        blk_data  = (st_q == IN_FULL) ? sh_q
                                      : {sh_q[BLK_W-BYTE_W-1:0], wr_data};
        blk_start = blk_ready && alg_free;
        in_ready  = (st_q == IN_LOAD);
    end

    // State, byte counter, shift register and transfer delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= IN_LOAD;
            cnt_q  <= '0;
            xcnt_q <= '0;
            sh_q   <= '0;
        end else begin
            case (st_q)
                IN_LOAD: begin
                    if (wr_fire) begin
                        sh_q <= blk_data;
                        if (last_byte) begin
                            cnt_q <= '0;
                            if (blk_start) begin
                                st_q   <= IN_XFER;
                                xcnt_q <= XW'(XFER_CYC - 1);
                            end else begin
                                st_q <= IN_FULL;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                IN_FULL: begin
                    if (blk_start) begin
                        st_q   <= IN_XFER;
                        xcnt_q <= XW'(XFER_CYC - 1);
                    end
                end
                IN_XFER: begin
                    if (xcnt_q == '0) st_q <= IN_LOAD;
                    else              xcnt_q <= xcnt_q - 1'b1;
                end
                default: st_q <= IN_LOAD;
            endcase
        end
    end

    // R2
    in_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(wr_en && (cnt_q == CW'(NBYTES - 1))));

    // R6
    in_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_ready) |=> $stable(sh_q));

endmodule

// File: rtl/blkpipe_alg.sv
// Module: stand-in processing unit with a fixed latency of ALG_LAT clocks.
// It computes rotl(din ^ KEY, ROT) when it takes a block, finishes ALG_LAT
// clocks later, and holds the result until the output side can take it.
// Assumes: start is asserted only while free is high; 0 <= ROT < BLK_W.
module blkpipe_alg #(
    parameter int              BLK_W   = 64,
    parameter int              ALG_LAT = 18,
    parameter int              ROT     = 8,
    parameter logic [BLK_W-1:0] KEY    = 64'hA5C3_0F96_5A3C_F069
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] din,
    input  logic             out_free,
    output logic             free,
    output logic             handoff,
    output logic [BLK_W-1:0] dout
);
    localparam int LW = $clog2(ALG_LAT + 1);

    logic             run_q;
    logic [LW-1:0]    cnt_q;
    logic [BLK_W-1:0] data_q;
    logic [BLK_W-1:0] mixed;
    logic [BLK_W-1:0] xf;
    logic             done;

    // Key mix ahead of the rotation.
    always_comb mixed = din ^ KEY;

    // The rotate amount picks between a plain pass and a rotation.
    generate
        if (ROT == 0) begin : g_norot
            always_comb xf = mixed;
        end else begin : g_rot
            always_comb xf = (mixed << ROT) | (mixed >> (BLK_W - ROT));
        end
    endgenerate

    // Completion and hand-over decode.
    always_comb begin
        done    = run_q && (cnt_q == '0);
        handoff = done && out_free;
        free    = !run_q || handoff;
        dout    = data_q;
    end

    // Busy flag, latency counter and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            cnt_q  <= LW'(ALG_LAT - 1);
            data_q <= xf;
        end else if (handoff) begin
            run_q <= 1'b0;
        end else if (run_q && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Checker counter: clocks since the last start, saturating.
    logic [LW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                        since_q <= LW'(ALG_LAT);
        else if (start)                    since_q <= '0;
        else if (since_q != LW'(ALG_LAT))  since_q <= since_q + 1'b1;
    end

    // R8
    alg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (since_q == LW'(ALG_LAT - 1)));

    // R9
    alg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !out_free && !start) |=> (done && $stable(dout)));

endmodule

// File: rtl/blkpipe_out.sv
// Module: output staging. Takes a finished block, waits XFER_CYC clocks,
// then serves it MSB first, one byte per accepted read, on a registered
// output.
// Assumes: load is asserted only while empty is high; XFER_CYC >= 1.
module blkpipe_out
    import blkpipe_pkg::*;
#(
    parameter int BLK_W    = 64,
    parameter int BYTE_W   = 8,
    parameter int XFER_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BLK_W-1:0]  din,
    input  logic              rd_en,
    output logic              empty,
    output logic              out_ready,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int NBYTES = BLK_W / BYTE_W;
    localparam int CW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int XW     = $clog2(XFER_CYC + 1);

    out_state_e        st_q;
    logic [BLK_W-1:0]  oreg_q;
    logic [CW-1:0]     cnt_q;
    logic [XW-1:0]     xcnt_q;
    logic [BYTE_W-1:0] rd_q;
    logic              rd_fire;

    // Flag and accept decode.
    always_comb begin
        empty     = (st_q == OUT_EMPTY);
        out_ready = (st_q == OUT_FULL);
        rd_fire   = rd_en && (st_q == OUT_FULL);
        rd_data   = rd_q;
    end

    // State, holding register, read counter and registered byte output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= OUT_EMPTY;
            oreg_q <= '0;
            cnt_q  <= '0;
            xcnt_q <= '0;
            rd_q   <= '0;
        end else begin
            case (st_q)
                OUT_EMPTY: begin
                    if (load) begin
                        oreg_q <= din;
                        xcnt_q <= XW'(XFER_CYC - 1);
                        st_q   <= OUT_XFER;
                    end
                end
                OUT_XFER: begin
                    if (xcnt_q == '0) begin
                        st_q  <= OUT_FULL;
                        cnt_q <= '0;
                    end else begin
                        xcnt_q <= xcnt_q - 1'b1;
                    end
                end
                OUT_FULL: begin
                    if (rd_fire) begin
                        rd_q   <= oreg_q[BLK_W-1 -: BYTE_W];
                        oreg_q <= oreg_q << BYTE_W;
                        if (cnt_q == CW'(NBYTES - 1)) begin
                            st_q  <= OUT_EMPTY;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= OUT_EMPTY;
            endcase
        end
    end

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !out_ready) |=> $stable(rd_data));

    // R5
    out_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_ready) |-> $past(rd_en));

    // R9
    load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> empty);

endmodule

// File: rtl/blkpipe_ctrl.sv
// Module: top of the overlapped byte-serial block pipeline. It connects the
// input staging, the processing stand-in and the output staging so that all
// three stages can work on different blocks at once.
// Assumes: one clock domain; a synchronous active-low reset.
module blkpipe_ctrl #(
    parameter int              BLK_W    = 64,
    parameter int              BYTE_W   = 8,
    parameter int              XFER_CYC = 5,
    parameter int              ALG_LAT  = 18,
    parameter int              ROT      = 8,
    parameter logic [BLK_W-1:0] KEY     = 64'hA5C3_0F96_5A3C_F069
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              in_ready,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              out_ready
);
    localparam int AW = $clog2(XFER_CYC + 2);

    logic             alg_free;
    logic             alg_start;
    logic [BLK_W-1:0] in_blk;
    logic             out_empty;
    logic             handoff;
    logic [BLK_W-1:0] alg_out;

    blkpipe_in #(.BLK_W(BLK_W), .BYTE_W(BYTE_W), .XFER_CYC(XFER_CYC)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .alg_free  (alg_free),
        .in_ready  (in_ready),
        .blk_start (alg_start),
        .blk_data  (in_blk)
    );

    blkpipe_alg #(.BLK_W(BLK_W), .ALG_LAT(ALG_LAT), .ROT(ROT), .KEY(KEY)) u_alg (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (alg_start),
        .din      (in_blk),
        .out_free (out_empty),
        .free     (alg_free),
        .handoff  (handoff),
        .dout     (alg_out)
    );

    blkpipe_out #(.BLK_W(BLK_W), .BYTE_W(BYTE_W), .XFER_CYC(XFER_CYC)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (handoff),
        .din       (alg_out),
        .rd_en     (rd_en),
        .empty     (out_empty),
        .out_ready (out_ready),
        .rd_data   (rd_data)
    );

    // Checker counters: clocks since each hand-over, saturating.
    logic [AW-1:0] in_age_q;
    logic [AW-1:0] out_age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_age_q  <= AW'(XFER_CYC + 1);
            out_age_q <= AW'(XFER_CYC + 1);
        end else begin
            if (alg_start)                          in_age_q <= '0;
            else if (in_age_q != AW'(XFER_CYC + 1)) in_age_q <= in_age_q + 1'b1;
            if (handoff)                             out_age_q <= '0;
            else if (out_age_q != AW'(XFER_CYC + 1)) out_age_q <= out_age_q + 1'b1;
        end
    end

    // R3
    in_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (in_age_q == AW'(XFER_CYC)));

    // R4
    out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ready) |-> (out_age_q == AW'(XFER_CYC)));

endmodule

// File: tb/blkpipe_ctrl_bench.sv
module blkpipe_ctrl_bench;
    localparam logic [63:0] KEY = 64'hA5C3_0F96_5A3C_F069;
    localparam int NVEC = 5;
    localparam logic [63:0] VEC [NVEC] = '{
        64'h0123_4567_89AB_CDEF,
        64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0001,
        64'hDEAD_BEEF_CAFE_F00D
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       in_ready;
    logic       out_ready;
    logic [7:0] rd_data;

    blkpipe_ctrl u_blkpipe_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .in_ready  (in_ready),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .out_ready (out_ready)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0;
    int fails = 0;

    int   in_rise = -1;
    logic in_prev = 1'b1;
    always @(negedge clk) begin
        if (in_ready && !in_prev) in_rise = cyc;
        in_prev = in_ready;
    end

    function automatic logic [63:0] ref_f(input logic [63:0] x);
        logic [63:0] t;
        t = x ^ KEY;
        return {t[55:0], t[63:56]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_block(input logic [63:0] b, input int junk,
                               output int c7, output int t_seen);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        t_seen = cyc;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            wr_en   = 1'b1;
            wr_data = b[63-8*i -: 8];
        end
        c7 = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 in_ready low after eighth byte", 64'(in_ready), 64'd0);
        for (int j = 0; j < junk; j++) begin
            wr_en   = 1'b1;
            wr_data = 8'hEE;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic read_block(output logic [63:0] got, output int t_rdy, output int t_end);
        @(negedge clk);
        while (!out_ready) @(negedge clk);
        t_rdy = cyc;
        rd_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            got[63-8*i -: 8] = rd_data;
        end
        rd_en = 1'b0;
        t_end = cyc;
        chk("R5 out_ready low after eighth read", 64'(out_ready), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int c7a, c7b, c7c, ts, tsc, ta, tb, tc, te;
        logic [63:0] ga, gb, gc;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 in_ready at reset", 64'(in_ready), 64'd1);
        chk("R1 out_ready at reset", 64'(out_ready), 64'd0);
        chk("R1 rd_data at reset", 64'(rd_data), 64'd0);
        rst_n = 1'b1;

        // Table walk: isolated blocks with junk writes, then ignored reads.
        for (int v = 0; v < NVEC; v++) begin
            int c7, tw, tr, tend;
            logic [63:0] got;
            fork
                write_block(VEC[v], 3, c7, tw);
                read_block(got, tr, tend);
            join
            chk("R3 in_ready return edge", 64'(in_rise), 64'(c7 + 5));
            chk("R4 out_ready rise edge", 64'(tr), 64'(c7 + 23));
            chk("R5 R6 block data", got, ref_f(VEC[v]));
            // R7: strobes with out_ready low
            @(negedge clk);
            rd_en = 1'b1;
            repeat (2) @(negedge clk);
            rd_en = 1'b0;
            chk("R7 rd_data held", 64'(rd_data), 64'(got[7:0]));
            chk("R7 out_ready stays low", 64'(out_ready), 64'd0);
        end

        // R8: continuous traffic
        fork
            begin
                write_block(64'h1111_2222_3333_4444, 0, c7a, ts);
                write_block(64'h5555_6666_7777_8888, 0, c7b, ts);
                write_block(64'h9999_AAAA_BBBB_CCCC, 0, c7c, tsc);
            end
            begin
                read_block(ga, ta, te);
                read_block(gb, tb, te);
                read_block(gc, tc, te);
            end
        join
        chk("R4 first of stream", 64'(ta), 64'(c7a + 23));
        chk("R8 spacing first-second", 64'(tb - ta), 64'd18);
        chk("R8 spacing second-third", 64'(tc - tb), 64'd18);
        chk("R8 in_ready after queued start", 64'(tsc), 64'(c7a + 23));
        chk("R8 data first", ga, ref_f(64'h1111_2222_3333_4444));
        chk("R8 data second", gb, ref_f(64'h5555_6666_7777_8888));
        chk("R8 data third", gc, ref_f(64'h9999_AAAA_BBBB_CCCC));

        // R9: slow reader stalls the pipeline
        write_block(64'h0F0F_0F0F_F0F0_F0F0, 0, c7a, ts);
        write_block(64'h1234_5678_9ABC_DEF0, 0, c7b, ts);
        write_block(64'hFEDC_BA98_7654_3210, 0, c7c, ts);
        repeat (40) @(negedge clk);
        chk("R9 input held full", 64'(in_ready), 64'd0);
        chk("R9 output holds block", 64'(out_ready), 64'd1);
        read_block(ga, ta, te);
        read_block(gb, tb, tc);
        chk("R9 next out_ready after drain", 64'(tb), 64'(te + 6));
        chk("R9 waiting input starts on hand-over", 64'(in_rise), 64'(te + 6));
        read_block(gc, tc, te);
        chk("R9 data first", ga, ref_f(64'h0F0F_0F0F_F0F0_F0F0));
        chk("R9 data second", gb, ref_f(64'h1234_5678_9ABC_DEF0));
        chk("R9 data third", gc, ref_f(64'hFEDC_BA98_7654_3210));

        // R1: reset in the middle of a partial write
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_data = 8'h55;
        end
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 in_ready after mid reset", 64'(in_ready), 64'd1);
        chk("R1 out_ready after mid reset", 64'(out_ready), 64'd0);
        chk("R1 rd_data after mid reset", 64'(rd_data), 64'd0);
        rst_n = 1'b1;
        fork
            write_block(64'hA1B2_C3D4_E5F6_0718, 0, c7a, ts);
            read_block(ga, ta, te);
        join
        chk("R1 counter cleared, data", ga, ref_f(64'hA1B2_C3D4_E5F6_0718));
        chk("R4 after reset", 64'(ta), 64'(c7a + 23));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule